// File: doc/BRIEF.md
# Nibble-Written CHR Bank Register File

This block holds the eight 1 KiB pattern-table bank numbers of a cartridge-style memory mapper. The CPU programs each 8-bit bank number with two byte writes: one supplies the lower four bits and the other supplies the upper four bits. Only data lines 3:0 matter for either write. The eight registers are not at consecutive addresses. They sit in pairs in four separate 4 KiB regions of the CPU map. Only address bits 15:12, 3 and 2 are decoded.

On the video side, address bits 12:10 of the pattern fetch name one of the eight windows. The block returns that window's bank number combinationally. The caller adds the 10 low address bits to form the full pattern-memory address. A value written on one clock edge is seen by every video fetch from the next cycle on.

Top module: `chr_nibble_bank_file`

## Requirements
- R1: `chr_bank` equals the register chosen by `ppu_win` (window w uses slot w, w = 0..7), with no clock in the path.
- R2: After masking the CPU address with 0xF00C, the low/high nibble addresses are: slot 0 0xD000/0xD004, slot 1 0xD008/0xD00C, slot 2 0xA000/0xA004, slot 3 0xA008/0xA00C, slot 4 0xB000/0xB004, slot 5 0xB008/0xB00C, slot 6 0xE000/0xE004, slot 7 0xE008/0xE00C. Address bit 2 = 1 selects the high nibble and bit 3 = 1 selects the odd slot of the pair.
- R3: A low-nibble write sets register bits 3:0 to `cpu_data[3:0]`. It keeps bits 7:4 and ignores `cpu_data[7:4]`.
- R4: A high-nibble write sets register bits 7:4 to `cpu_data[3:0]`. It keeps bits 3:0 and ignores `cpu_data[7:4]`.
- R5: A synchronous active-low reset clears all eight registers to 0x00.
- R6: A write whose masked address is not in the R2 list (for example address bits 15:12 of 0x8, 0x9, 0xC or 0xF) changes no register.
- R7: Address bits outside the 0xF00C mask have no effect: 0xDFF3 writes the slot 0 low nibble, as 0xD000 does.
- R8: When `cpu_wr` is low, no register changes, whatever the address and data are.
- R9: A write sampled on a rising edge shows on `chr_bank` right after that edge and not before it. Writing 5 as the low nibble and then 1 as the high nibble gives bank 0x15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU-side clock; writes are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU data bus; only bits 3:0 are stored |
| cpu_wr | input | 1 | Write strobe, one cycle per write |
| ppu_win | input | 3 | Video address bits 12:10, the 1 KiB window number |
| chr_bank | output | 8 | Bank number for the selected window |

## Verification
On every cycle, the assertions check four things. The decoder never drives more than one nibble strobe. No strobe fires without `cpu_wr`. A nibble write changes only its own half of a register, and only from data bits 3:0. A write to an undecoded region or a reset leaves the registers unchanged or cleared. Only the directed scenarios show the rest: the address map landing on the right slot for each of the sixteen addresses, aliasing of the unmasked address bits, the exact cycle in which a new value appears on `chr_bank`, and the window-to-slot selection seen at the output.

// File: rtl/chr_bank_pkg.sv
// Package: shared constants for the CHR bank register file.
// Assumes a 16-bit CPU address, 8-bit bank numbers split into two
// 4-bit halves, and eight 1 KiB video windows.
package chr_bank_pkg;
    localparam int CPU_ADDR_W = 16;
    localparam int NIB_W      = 4;
    localparam int BANK_W     = 2 * NIB_W;
    localparam int SLOT_CNT   = 8;
    localparam int WIN_W      = $clog2(SLOT_CNT);

    // Address bits that take part in register decoding
    localparam logic [CPU_ADDR_W-1:0] REG_MASK = 16'hF00C;
    localparam logic [CPU_ADDR_W-1:0] HI_BIT   = 16'h0004;
    localparam logic [CPU_ADDR_W-1:0] ODD_BIT  = 16'h0008;

    // Result of decoding the upper four address bits
    typedef struct packed {
        logic       valid;
        logic [1:0] pair;
    } region_t;

    // Map a 4 KiB region number onto a register pair; unmapped regions are invalid
    function automatic region_t region_lookup(input logic [3:0] region);
        region_t r;
        r.valid = 1'b1;
        case (region)
            4'hD:    r.pair = 2'd0;
            4'hA:    r.pair = 2'd1;
            4'hB:    r.pair = 2'd2;
            4'hE:    r.pair = 2'd3;
            default: begin
                r.valid = 1'b0;
                r.pair  = 2'd0;
            end
        endcase
        return r;
    endfunction
endpackage

// File: rtl/chr_reg_decode.sv
// Module: chr_reg_decode
// Turns a CPU write into at most one low-nibble or high-nibble strobe
// for one of the slot registers. Assumes cpu_wr is a single-cycle
// strobe and that only address bits 15:12, 3 and 2 are significant.
module chr_reg_decode
    import chr_bank_pkg::*;
#(
    parameter int ADDR_W = CPU_ADDR_W,
    parameter int SLOTS  = SLOT_CNT,
    parameter int SEL_W  = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_wr,
    output logic [SLOTS-1:0]  wr_lo,
    output logic [SLOTS-1:0]  wr_hi
);
    logic [ADDR_W-1:0] masked;
    region_t           region;
    logic              odd_sel;
    logic              hi_sel;
    logic [SEL_W-1:0]  slot_idx;

    // Keep only the decoded address lines
    always_comb masked = cpu_addr & ADDR_W'(REG_MASK);

    // Split the masked address into region, pair member and nibble half
    always_comb begin
        region   = region_lookup(4'(masked >> (ADDR_W - 4)));
        odd_sel  = |(masked & ADDR_W'(ODD_BIT));
        hi_sel   = |(masked & ADDR_W'(HI_BIT));
        slot_idx = SEL_W'({region.pair, odd_sel});
    end

    // Raise the strobe of the addressed slot and nibble half
    always_comb begin
        for (int i = 0; i < SLOTS; i++) begin
            wr_lo[i] = cpu_wr && region.valid && (slot_idx == SEL_W'(i)) && !hi_sel;
            wr_hi[i] = cpu_wr && region.valid && (slot_idx == SEL_W'(i)) &&  hi_sel;
        end
    end

    // R2: a write reaches at most one nibble of one slot
    p_single_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_lo, wr_hi}));

    // R8: no strobe without the CPU write strobe
    p_no_strobe_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_wr |-> (wr_lo == '0) && (wr_hi == '0));
endmodule

// File: rtl/chr_slot_reg.sv
// Module: chr_slot_reg
// One bank-number register loaded half at a time. Assumes the two
// strobes are never high together; the low half wins if they are.
module chr_slot_reg #(
    parameter int NIBW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [NIBW-1:0]   nib_in,
    output logic [2*NIBW-1:0] q
);
    // Clear on reset, otherwise replace the strobed half only
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (wr_lo)
            q[NIBW-1:0] <= nib_in;
        else if (wr_hi)
            q[2*NIBW-1:NIBW] <= nib_in;
    end

    // R3: a low write loads the data nibble and keeps the upper half
    p_low_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> (q[NIBW-1:0] == $past(nib_in)) &&
                  (q[2*NIBW-1:NIBW] == $past(q[2*NIBW-1:NIBW])));

    // R4: a high write loads the data nibble and keeps the lower half
    p_high_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && !wr_lo) |=> (q[2*NIBW-1:NIBW] == $past(nib_in)) &&
                              (q[NIBW-1:0] == $past(q[NIBW-1:0])));

    // R5: the register is zero on the first cycle after reset
    p_reset_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (q == '0));
endmodule

// File: rtl/chr_bank_mux.sv
// Module: chr_bank_mux
// Combinational choice of the bank number for the current video window.
// Assumes SLOTS is a power of two so every select value names a slot.
module chr_bank_mux #(
    parameter int SLOTS  = 8,
    parameter int BANK_W = 8,
    parameter int SEL_W  = $clog2(SLOTS)
) (
    input  logic [SLOTS-1:0][BANK_W-1:0] regs,
    input  logic [SEL_W-1:0]             sel,
    output logic [BANK_W-1:0]            bank
);
    // Pick the slot named by the window number
    always_comb bank = regs[sel];
endmodule

// File: rtl/chr_nibble_bank_file.sv
// Module: chr_nibble_bank_file
// Top of the CHR bank register file: decodes CPU writes into per-slot
// nibble strobes, holds eight bank registers and returns the bank of
// the window on ppu_win. Assumes one write per cpu_wr pulse and a video
// side that samples chr_bank combinationally.
module chr_nibble_bank_file
    import chr_bank_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CPU_ADDR_W-1:0] cpu_addr,
    input  logic [BANK_W-1:0]     cpu_data,
    input  logic                  cpu_wr,
    input  logic [WIN_W-1:0]      ppu_win,
    output logic [BANK_W-1:0]     chr_bank
);
    logic [SLOT_CNT-1:0]             wr_lo;
    logic [SLOT_CNT-1:0]             wr_hi;
    logic [NIB_W-1:0]                nib;
    logic [SLOT_CNT-1:0][BANK_W-1:0] bank_regs;

    // Only the low data lines carry a nibble
    always_comb nib = NIB_W'(cpu_data);

    chr_reg_decode #(
        .ADDR_W (CPU_ADDR_W),
        .SLOTS  (SLOT_CNT)
    ) u_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_addr (cpu_addr),
        .cpu_wr   (cpu_wr),
        .wr_lo    (wr_lo),
        .wr_hi    (wr_hi)
    );

    for (genvar s = 0; s < SLOT_CNT; s++) begin : g_slot
        chr_slot_reg #(
            .NIBW (NIB_W)
        ) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_lo  (wr_lo[s]),
            .wr_hi  (wr_hi[s]),
            .nib_in (nib),
            .q      (bank_regs[s])
        );
    end

    chr_bank_mux #(
        .SLOTS  (SLOT_CNT),
        .BANK_W (BANK_W)
    ) u_mux (
        .regs (bank_regs),
        .sel  (ppu_win),
        .bank (chr_bank)
    );

    // R6: a write outside the four decoded regions changes no register
    p_unmapped_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !(cpu_addr[15:12] inside {4'hA, 4'hB, 4'hD, 4'hE}))
        |=> $stable(bank_regs));

    // R8: without a write strobe every register holds
    p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_wr |=> $stable(bank_regs));
endmodule

// File: tb/tb_chr_nibble_bank_file.sv
// Directed bench for chr_nibble_bank_file. Inputs change on the falling
// edge, outputs are sampled 1 ns later; a model array tracks expected banks.
module tb_chr_nibble_bank_file;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_data = 8'h00;
    logic        cpu_wr = 1'b0;
    logic [2:0]  ppu_win = 3'd0;
    logic [7:0]  chr_bank;

    int checks = 0;
    int errors = 0;
    logic [7:0]  model [8];
    logic [15:0] lo_addr [8];

    always #2 clk = ~clk;

    chr_nibble_bank_file dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_addr (cpu_addr),
        .cpu_data (cpu_data),
        .cpu_wr   (cpu_wr),
        .ppu_win  (ppu_win),
        .chr_bank (chr_bank)
    );

    // Compare the output for one window with an expected value
    task automatic check_win(input int w, input logic [7:0] exp, input string req);
        ppu_win = 3'(w);
        #1;
        checks++;
        if (chr_bank !== exp) begin
            errors++;
            $display("FAIL %s window %0d actual=%02h expected=%02h", req, w, chr_bank, exp);
        end
    endtask

    // Check all eight windows against the model
    task automatic check_all(input string req);
        for (int w = 0; w < 8; w++) check_win(w, model[w], req);
    endtask

    // One CPU write cycle; the caller updates the model
    task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a;
        cpu_data = d;
        cpu_wr   = 1'b1;
        @(negedge clk);
        cpu_wr   = 1'b0;
        cpu_addr = 16'h0000;
    endtask

    task automatic set_lo(input int s, input logic [7:0] d);
        cpu_write(lo_addr[s], d);
        model[s][3:0] = d[3:0];
    endtask

    task automatic set_hi(input int s, input logic [7:0] d);
        cpu_write(lo_addr[s] | 16'h0004, d);
        model[s][7:4] = d[3:0];
    endtask

    // R5: registers read zero after reset
    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int s = 0; s < 8; s++) model[s] = 8'h00;
        check_all("R5");
    endtask

    // R9, R3, R4: the worked example gives 0x15
    task automatic t_example();
        set_lo(0, 8'h05);
        check_win(0, 8'h05, "R3");
        set_hi(0, 8'h01);
        check_win(0, 8'h15, "R9");
    endtask

    // R2, R1: each slot gets a distinct value at its own address pair
    task automatic t_all_slots();
        for (int s = 0; s < 8; s++) begin
            set_lo(s, 8'(s + 8'h3));
            set_hi(s, 8'(8'h9 - s));
        end
        check_all("R2");
        for (int w = 7; w >= 0; w--) check_win(w, model[w], "R1");
    endtask

    // R3, R4: upper data bits ignored, other half kept
    task automatic t_half_keep();
        set_lo(3, 8'hFA);
        check_win(3, model[3], "R3");
        set_hi(5, 8'hE2);
        check_win(5, model[5], "R4");
        check_all("R4");
    endtask

    // R6: unmapped regions change nothing
    task automatic t_unmapped();
        cpu_write(16'h8000, 8'h0F);
        cpu_write(16'h9004, 8'h0F);
        cpu_write(16'hC008, 8'h0F);
        cpu_write(16'hF00C, 8'h0F);
        cpu_write(16'h1000, 8'h0F);
        check_all("R6");
    endtask

    // R7: unmasked address bits alias onto the decoded register
    task automatic t_alias();
        cpu_write(16'hDFF3, 8'h07);
        model[0][3:0] = 4'h7;
        cpu_write(16'hBAB6, 8'h0C);
        model[4][7:4] = 4'hC;
        check_win(0, model[0], "R7");
        check_win(4, model[4], "R7");
    endtask

    // R8: address and data without the strobe change nothing
    task automatic t_no_strobe();
        @(negedge clk);
        cpu_addr = 16'hE008;
        cpu_data = 8'h0B;
        @(negedge clk);
        cpu_addr = 16'hA004;
        @(negedge clk);
        cpu_addr = 16'h0000;
        check_all("R8");
    endtask

    // R9, R1: new value appears only after the capturing edge, with no clock on the read path
    task automatic t_timing();
        @(negedge clk);
        cpu_addr = 16'hE00C;
        cpu_data = 8'h06;
        cpu_wr   = 1'b1;
        check_win(7, model[7], "R9");
        @(posedge clk);
        #1;
        cpu_wr = 1'b0;
        model[7][7:4] = 4'h6;
        checks++;
        ppu_win = 3'd7;
        #0.5;
        if (chr_bank !== model[7]) begin
            errors++;
            $display("FAIL R9 after edge actual=%02h expected=%02h", chr_bank, model[7]);
        end
        ppu_win = 3'd2;
        #0.5;
        checks++;
        if (chr_bank !== model[2]) begin
            errors++;
            $display("FAIL R1 combinational select actual=%02h expected=%02h", chr_bank, model[2]);
        end
    endtask

    initial begin
        lo_addr[0] = 16'hD000; lo_addr[1] = 16'hD008;
        lo_addr[2] = 16'hA000; lo_addr[3] = 16'hA008;
        lo_addr[4] = 16'hB000; lo_addr[5] = 16'hB008;
        lo_addr[6] = 16'hE000; lo_addr[7] = 16'hE008;
        t_reset();
        t_example();
        t_all_slots();
        t_half_keep();
        t_unmapped();
        t_alias();
        t_no_strobe();
        t_timing();
        t_reset();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        #800000;
        checks++;
        errors++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule